// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block decides which control-memory word a microprogrammed control unit reads next. It holds a 7-bit microinstruction address register, whose value drives the control-memory address, and a single-entry return register for subroutine linkage. Each cycle it takes the condition-select, branch-kind and target-address fields of the microinstruction being executed, three status bits from the datapath and the 4-bit opcode of the current machine instruction. From these it loads the address register from one of four sources.

A condition multiplexer picks one test bit from a constant one, the indirect bit, the sign bit or the accumulator-zero flag. A decode stage turns the branch kind and the test bit into a two-bit source select and a load enable for the return register. A source multiplexer then chooses among four inputs: the incremented address, the target field, the saved return address, and an address formed from the opcode. The control-memory contents and the datapath that produces the status bits lie outside this block.

Top module: `mseq_next_addr`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the address to 64 and clears the return register to 0.
- R2: The test bit is chosen by cond_sel: 2'b00 gives 1, 2'b01 gives ind_bit, 2'b10 gives sign_bit, 2'b11 gives acc_zero.
- R3: With br_op = 2'b00 (jump), the next address is br_target when the test bit is 1 and the current address plus one when it is 0.
- R4: With br_op = 2'b01 (call) and the test bit 1, the next address is br_target and the return register takes the current address plus one.
- R5: With br_op = 2'b01 (call) and the test bit 0, the next address is the current address plus one and the return register keeps its value.
- R6: With br_op = 2'b10 (return), the next address is the return register's value, whatever the test bit.
- R7: With br_op = 2'b11 (map), the next address is {1'b0, opcode, 2'b00}, whatever the test bit.
- R8: The incremented address wraps from 127 to 0, both for the next address and for the saved return address.
- R9: The return register holds one entry, so a taken call inside a subroutine replaces the earlier return address.
- R10: The internal source select uses 2'b00 for the increment, 2'b01 for the target field, 2'b10 for the return register and 2'b11 for the mapped opcode, and the return register loads only when the target field is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 2 | Condition-select field of the current microinstruction |
| br_op | input | 2 | Branch-kind field: jump, call, return, map |
| br_target | input | 7 | Target-address field of the current microinstruction |
| ind_bit | input | 1 | Indirect-addressing status bit |
| sign_bit | input | 1 | Accumulator sign status bit |
| acc_zero | input | 1 | Accumulator-is-zero status bit |
| opcode | input | 4 | Opcode of the current machine instruction |
| uaddr | output | 7 | Current control-memory address |

## Verification
The assertions assume that every field and status input is a known 0 or 1 at each rising edge outside reset. They also assume that a return issued without an earlier call is still legal and yields the reset value 0 of the return register. The bench drives all inputs to defined values on the falling edge, holds rst high for the first cycles, and compares against a behavioural model on every clock. Directed steps cover each test source at both polarities and the wrap at 127. A seeded random phase then mixes all branch kinds, including calls nested inside subroutines and returns with no pending call.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int AW   = 7;
    localparam int OW   = 4;
    localparam int PAD  = AW - OW - 1;
    localparam logic [AW-1:0] BOOT_ADDR = AW'(64);

    typedef enum logic [1:0] {
        COND_ALWAYS = 2'b00,
        COND_IND    = 2'b01,
        COND_SIGN   = 2'b10,
        COND_ZERO   = 2'b11
    } cond_e;

    typedef enum logic [1:0] {
        BR_JMP  = 2'b00,
        BR_CALL = 2'b01,
        BR_RET  = 2'b10,
        BR_MAP  = 2'b11
    } br_e;

    typedef enum logic [1:0] {
        SRC_INC    = 2'b00,
        SRC_BRANCH = 2'b01,
        SRC_RET    = 2'b10,
        SRC_MAP    = 2'b11
    } src_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] ret;
    } seq_state_t;

endpackage

// File: rtl/useq_test_mux.sv
module useq_test_mux
    import useq_pkg::*;
(
    input  logic [1:0] cond_sel,
    input  logic       ind_bit,
    input  logic       sign_bit,
    input  logic       acc_zero,
    output logic       test_bit
);
    localparam int NSRC = 4;

    logic [NSRC-1:0] stat_vec;

    always_comb begin
        stat_vec[COND_ALWAYS] = 1'b1;
        stat_vec[COND_IND]    = ind_bit;
        stat_vec[COND_SIGN]   = sign_bit;
        stat_vec[COND_ZERO]   = acc_zero;
    end

    assign test_bit = stat_vec[cond_sel];

endmodule

// File: rtl/useq_branch_decode.sv
module useq_branch_decode
    import useq_pkg::*;
(
    input  logic [1:0] br_op,
    input  logic       test_bit,
    output logic [1:0] src_sel,
    output logic       ret_load
);
    logic op_hi;
    logic op_lo;

    always_comb begin
        op_hi      = br_op[1];
        op_lo      = br_op[0];
        src_sel[1] = op_hi;
        src_sel[0] = (op_hi & op_lo) | (~op_hi & test_bit);
        ret_load   = ~op_hi & op_lo & test_bit;
    end

    // R10: a return-register load only goes with the target-field source
    always_comb begin
        assert_load_with_branch_R10: assert (!ret_load || src_sel == SRC_BRANCH);
    end

endmodule

// File: rtl/useq_src_mux.sv
module useq_src_mux
    import useq_pkg::*;
(
    input  logic [1:0]    src_sel,
    input  logic [AW-1:0] inc_addr,
    input  logic [AW-1:0] tgt_addr,
    input  logic [AW-1:0] ret_addr,
    input  logic [AW-1:0] map_addr,
    output logic [AW-1:0] next_addr
);
    always_comb begin
        unique case (src_sel)
            SRC_INC:    next_addr = inc_addr;
            SRC_BRANCH: next_addr = tgt_addr;
            SRC_RET:    next_addr = ret_addr;
            default:    next_addr = map_addr;
        endcase
    end

endmodule

// File: rtl/mseq_next_addr.sv
module mseq_next_addr
    import useq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cond_sel,
    input  logic [1:0]    br_op,
    input  logic [AW-1:0] br_target,
    input  logic          ind_bit,
    input  logic          sign_bit,
    input  logic          acc_zero,
    input  logic [OW-1:0] opcode,
    output logic [AW-1:0] uaddr
);
    seq_state_t    st_q;
    seq_state_t    st_d;
    logic          test_bit;
    logic [1:0]    src_sel;
    logic          ret_load;
    logic [AW-1:0] inc_addr;
    logic [AW-1:0] map_addr;
    logic [AW-1:0] next_addr;

    useq_test_mux u_test (
        .cond_sel (cond_sel),
        .ind_bit  (ind_bit),
        .sign_bit (sign_bit),
        .acc_zero (acc_zero),
        .test_bit (test_bit)
    );

    useq_branch_decode u_dec (
        .br_op    (br_op),
        .test_bit (test_bit),
        .src_sel  (src_sel),
        .ret_load (ret_load)
    );

    assign inc_addr = st_q.addr + AW'(1);
    assign map_addr = {1'b0, opcode, {PAD{1'b0}}};

    useq_src_mux u_mux (
        .src_sel   (src_sel),
        .inc_addr  (inc_addr),
        .tgt_addr  (br_target),
        .ret_addr  (st_q.ret),
        .map_addr  (map_addr),
        .next_addr (next_addr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.addr = next_addr;
        if (ret_load) begin
            st_d.ret = inc_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.addr <= BOOT_ADDR;
            st_q.ret  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign uaddr = st_q.addr;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (st_q.addr == BOOT_ADDR && st_q.ret == '0));

    assert_always_R2: assert property (@(posedge clk) disable iff (rst)
        (br_op == BR_JMP && cond_sel == COND_ALWAYS) |=> st_q.addr == $past(br_target));

    assert_jump_R3: assert property (@(posedge clk) disable iff (rst)
        (br_op == BR_JMP && test_bit) |=> st_q.addr == $past(br_target));

    assert_call_R4: assert property (@(posedge clk) disable iff (rst)
        (br_op == BR_CALL && test_bit) |=> (st_q.addr == $past(br_target)
                                            && st_q.ret == $past(st_q.addr + AW'(1))));

    assert_call_skip_R5: assert property (@(posedge clk) disable iff (rst)
        (br_op == BR_CALL && !test_bit) |=> $stable(st_q.ret));

    assert_return_R6: assert property (@(posedge clk) disable iff (rst)
        (br_op == BR_RET) |=> st_q.addr == $past(st_q.ret));

    assert_map_R7: assert property (@(posedge clk) disable iff (rst)
        (br_op == BR_MAP) |=> st_q.addr == {1'b0, $past(opcode), {PAD{1'b0}}});

    assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (br_op == BR_JMP && !test_bit && st_q.addr == '1) |=> st_q.addr == '0);

endmodule

// File: tb/sim_mseq_next_addr.sv
module sim_mseq_next_addr;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cond_sel = 2'b00;
    logic [1:0] br_op = 2'b00;
    logic [6:0] br_target = 7'd0;
    logic       ind_bit = 1'b0;
    logic       sign_bit = 1'b0;
    logic       acc_zero = 1'b0;
    logic [3:0] opcode = 4'd0;
    logic [6:0] uaddr;

    int total = 0;
    int bad = 0;
    int m_addr = 64;
    int m_ret = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mseq_next_addr u0 (
        .clk       (clk),
        .rst       (rst),
        .cond_sel  (cond_sel),
        .br_op     (br_op),
        .br_target (br_target),
        .ind_bit   (ind_bit),
        .sign_bit  (sign_bit),
        .acc_zero  (acc_zero),
        .opcode    (opcode),
        .uaddr     (uaddr)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: uaddr actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int cd, input int br, input int ad,
                        input bit i, input bit s, input bit z, input int op,
                        input string tag);
        bit t;
        cond_sel  = 2'(cd);
        br_op     = 2'(br);
        br_target = 7'(ad);
        ind_bit   = i;
        sign_bit  = s;
        acc_zero  = z;
        opcode    = 4'(op);
        case (cd)
            0: t = 1'b1;
            1: t = i;
            2: t = s;
            default: t = z;
        endcase
        case (br)
            0: m_addr = t ? ad : (m_addr + 1) % 128;
            1: begin
                if (t) begin
                    m_ret  = (m_addr + 1) % 128;
                    m_addr = ad;
                end else begin
                    m_addr = (m_addr + 1) % 128;
                end
            end
            2: m_addr = m_ret;
            default: m_addr = op * 4;
        endcase
        @(posedge clk);
        @(negedge clk);
        check(tag, int'(uaddr), m_addr);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        br_op = 2'($urandom_range(0, 3));
        br_target = 7'($urandom_range(0, 127));
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_addr = 64;
        m_ret = 0;
        check("R1 reset address", int'(uaddr), 64);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset address", int'(uaddr), 64);
        step(0, 2, 99, 1, 1, 1, 0, "R1 return after reset gives 0");
        step(0, 0, 10, 0, 0, 0, 0, "R2 R3 always-true jump");
        step(1, 0, 50, 0, 1, 1, 0, "R2 R3 indirect=0 falls through");
        step(1, 0, 20, 1, 0, 0, 0, "R2 R3 indirect=1 jumps");
        step(2, 0, 30, 0, 1, 0, 0, "R2 R3 sign=1 jumps");
        step(2, 0, 90, 1, 0, 1, 0, "R2 R3 sign=0 falls through");
        step(3, 0, 40, 0, 0, 1, 0, "R2 R3 zero=1 jumps");
        step(3, 0, 90, 1, 1, 0, 0, "R2 R3 zero=0 falls through");
        step(1, 1, 77, 0, 0, 0, 0, "R5 call not taken increments");
        step(0, 2, 5, 0, 0, 0, 0, "R5 return register untouched by skipped call");
        step(0, 0, 33, 0, 0, 0, 0, "R3 jump to 33");
        step(0, 1, 100, 0, 0, 0, 0, "R4 taken call to 100");
        step(2, 1, 110, 0, 1, 0, 0, "R9 nested call to 110");
        step(3, 2, 0, 0, 0, 0, 0, "R9 R6 return gives latest link 101");
        step(0, 3, 9, 0, 0, 0, 11, "R7 map opcode 1011 gives 44");
        step(1, 3, 9, 0, 0, 0, 15, "R7 map opcode 1111 gives 60");
        step(2, 3, 9, 1, 1, 1, 0, "R7 map opcode 0000 gives 0");
        step(0, 0, 127, 0, 0, 0, 0, "R3 jump to 127");
        step(1, 0, 3, 0, 0, 0, 0, "R8 increment wraps to 0");
        step(0, 0, 127, 0, 0, 0, 0, "R3 jump to 127 again");
        step(0, 1, 64, 0, 0, 0, 0, "R8 R4 call from 127");
        step(2, 2, 12, 0, 0, 0, 0, "R8 R6 saved link wrapped to 0");
        step(0, 3, 0, 0, 0, 0, 6, "R10 map source selected");
        do_reset();
        step(0, 2, 1, 0, 0, 0, 0, "R1 return register cleared by reset");
        for (int k = 0; k < 400; k++) begin
            step($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 127),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), $urandom_range(0, 15),
                 "R2 R3 R4 R5 R6 R7 R9 random mix");
        end
        do_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not end actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule